// File: doc/BRIEF.md
# Keyed Low-Voltage I/O Domain Enable Bank

This block holds one enable flag per I/O supply domain and drives a vector of enable outputs toward the pad ring. Software reaches each domain through its own 32-bit register on a simple register bus. A domain is switched on only when the low half-word of a write to its register carries one exact key value. Any other write switches the domain off, so a stray or corrupted write can never turn a low-voltage mode on by accident.

Reads do not return the written value. They return a normalised status word, 1 when the domain is enabled and 0 when it is not, so software can confirm the switch with a single compare. The domain registers sit at consecutive word addresses from a fixed base. The domain count is a parameter, and any access that falls outside the bank is harmless.

Top module: `lv_enable_bank`

## Requirements
- R1: After reset every bit of `lvEnable` is 0, and every domain register reads 32'h0000_0000.
- R2: A bus write to address BASE_OFFSET + 4*i (default base 0x050) whose bits 15:0 equal KEY (default 16'h1018) sets `lvEnable[i]` at the next rising clock edge.
- R3: A bus write to domain i whose bits 15:0 differ from KEY clears `lvEnable[i]` at the next rising clock edge. This includes the value 0 and values one bit away from KEY.
- R4: Bits 31:16 of the write data have no effect. 32'hFFFF_1018 enables a domain, and 32'h1018_0000 disables it.
- R5: While a read of domain i is presented, `busRdata` is combinationally 32'h0000_0001 if `lvEnable[i]` is 1 and 32'h0000_0000 otherwise. Bits 31:1 are always 0.
- R6: Writes below the base, at or beyond BASE_OFFSET + 4*NUM_DOMAINS, or to an address whose bits 1:0 are not 00 change no bit of `lvEnable`.
- R7: `busRdata` is 0 for reads outside the bank as defined in R6, and whenever `busSel` is 0 or `busWrite` is 1.
- R8: A write changes at most the addressed domain's enable. All other bits of `lvEnable` keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (12) | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read status word, combinational |
| lvEnable | output | NUM_DOMAINS (8) | Per-domain low-voltage enables |

## Verification
The bench builds the block with NUM_DOMAINS set to 5 and keeps the default base and key. With five domains the bank ends at 0x064, which is not a power-of-two boundary. The addresses 0x064 to 0x06C still decode to a slot index the index width can hold, so the bench can show that the bound compare, and not the index width, rejects them. It also drives the key with its upper half-word set, near-miss keys, and misaligned addresses, all against domains that are already enabled, so any unwanted clear shows up on `lvEnable`.

// File: rtl/lv_enable_pkg.sv
package lv_enable_pkg;

  localparam int SLOT_W = 8;

  typedef struct packed {
    logic              wrStb;
    logic              rdStb;
    logic              keyHit;
    logic [SLOT_W-1:0] slot;
  } bankStrobeT;

endpackage

// File: rtl/lv_enable_ctrl.sv
module lv_enable_ctrl
  import lv_enable_pkg::*;
#(
  parameter int          NUM_DOMAINS = 8,
  parameter int          ADDR_W      = 12,
  parameter int          KEY_W       = 16,
  parameter logic [15:0] KEY         = 16'h1018,
  parameter int          BASE_OFFSET = 'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output bankStrobeT        stb
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFFSET);
  localparam logic [ADDR_W-1:0] LIMIT  = ADDR_W'(NUM_DOMAINS);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] wordIdx;
  logic              inBank;

  always_comb begin
    offset  = busAddr - BASE_A;
    wordIdx = offset >> 2;
    inBank  = (busAddr >= BASE_A) && (offset[1:0] == 2'b00) && (wordIdx < LIMIT);
    stb.wrStb  = busSel && busWrite && inBank;
    stb.rdStb  = busSel && !busWrite && inBank;
    stb.keyHit = (busWdata[KEY_W-1:0] == KEY[KEY_W-1:0]);
    stb.slot   = SLOT_W'(wordIdx);
  end

  // R6: misaligned writes never reach the datapath
  a_r6_misaligned_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr[1:0] != 2'b00) |-> !stb.wrStb);

  // R6: writes below the base never reach the datapath
  a_r6_below_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr < BASE_A) |-> !stb.wrStb);

endmodule

// File: rtl/lv_enable_dp.sv
module lv_enable_dp
  import lv_enable_pkg::*;
#(
  parameter int NUM_DOMAINS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bankStrobeT             stb,
  output logic [NUM_DOMAINS-1:0] enOut,
  output logic                   rdBit
);

  localparam int IDX_W = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1;

  logic [NUM_DOMAINS-1:0] enReg;
  logic [(2**IDX_W)-1:0]  enPad;

  for (genvar i = 0; i < NUM_DOMAINS; i++) begin : g_dom
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        enReg[i] <= 1'b0;
      else if (stb.wrStb && stb.slot == SLOT_W'(i))
        enReg[i] <= stb.keyHit;
    end
  end

  always_comb begin
    rdBit = 1'b0;
    for (int i = 0; i < NUM_DOMAINS; i++)
      if (stb.rdStb && stb.slot == SLOT_W'(i)) rdBit = enReg[i];
  end

  assign enOut = enReg;
  assign enPad = (2**IDX_W)'(enReg);

  // R2: key write sets the addressed domain
  a_r2_key_sets: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && stb.keyHit) |=> enPad[$past(stb.slot[IDX_W-1:0])]);

  // R3: non-key write clears the addressed domain
  a_r3_nokey_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && !stb.keyHit) |=> !enPad[$past(stb.slot[IDX_W-1:0])]);

  // R6: no in-bank write, no change
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrStb |=> $stable(enReg));

  // R8: one write touches at most one domain
  a_r8_single_change: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |=> ($countones(enReg ^ $past(enReg)) <= 1));

endmodule

// File: rtl/lv_enable_bank.sv
module lv_enable_bank
  import lv_enable_pkg::*;
#(
  parameter int          NUM_DOMAINS = 8,
  parameter int          ADDR_W      = 12,
  parameter int          KEY_W       = 16,
  parameter logic [15:0] KEY         = 16'h1018,
  parameter int          BASE_OFFSET = 'h50
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  output logic [NUM_DOMAINS-1:0] lvEnable
);

  bankStrobeT stb;
  logic       rdBit;

  lv_enable_ctrl #(
    .NUM_DOMAINS(NUM_DOMAINS), .ADDR_W(ADDR_W), .KEY_W(KEY_W),
    .KEY(KEY), .BASE_OFFSET(BASE_OFFSET)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  lv_enable_dp #(.NUM_DOMAINS(NUM_DOMAINS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .enOut(lvEnable), .rdBit(rdBit)
  );

  assign busRdata = {31'b0, rdBit};

  // R5: status word carries only bit 0
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[31:1] == 31'b0);

  // R7: no read, no data
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel || busWrite) |-> busRdata == 32'b0);

endmodule

// File: tb/lv_enable_bank_tb_top.sv
module lv_enable_bank_tb_top;

  localparam int ND = 5;
  localparam logic [15:0] KEYV = 16'h1018;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [ND-1:0] lvEnable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [ND-1:0] expEn = '0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  lv_enable_bank #(.NUM_DOMAINS(ND)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .lvEnable(lvEnable)
  );

  // monitor: compares every presented read with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (busSel && !busWrite && expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (busRdata !== e) begin
          errors++;
          $display("FAIL %s read addr %h actual %h expected %h", t, busAddr, busRdata, e);
        end
      end
    end
  end

  function automatic bit inBank(input logic [11:0] a);
    return (a >= 12'h050) && (a[1:0] == 2'b00) && (((a - 12'h050) >> 2) < ND);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    if (inBank(a)) expEn[(a - 12'h050) >> 2] = (d[15:0] == KEYV);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    e = inBank(a) ? {31'b0, expEn[(a - 12'h050) >> 2]} : 32'b0;
    @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(tag);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic chkEn(input string tag);
    #1;
    checks++;
    if (lvEnable !== expEn) begin
      errors++;
      $display("FAIL %s lvEnable actual %b expected %b", tag, lvEnable, expEn);
    end
  endtask

  task automatic chkIdle(input string tag);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b1; busAddr = 12'h050;
    #1;
    checks++;
    if (busRdata !== 32'b0) begin
      errors++;
      $display("FAIL %s idle rdata actual %h expected %h", tag, busRdata, 32'b0);
    end
    busWrite = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkEn("R1");
    rstN = 1'b1;
    chkEn("R1");
    for (int i = 0; i < ND; i++) rd(12'(12'h050 + 4 * i), "R1");

    wr(12'h050, 32'h0000_1018); chkEn("R2");
    rd(12'h050, "R5");
    rd(12'h054, "R5");
    wr(12'h054, 32'h0000_1018); chkEn("R8");
    wr(12'h060, 32'hFFFF_1018); chkEn("R4");
    rd(12'h060, "R4");
    wr(12'h050, 32'h1018_0000); chkEn("R4");
    rd(12'h050, "R3");
    wr(12'h060, 32'h0000_0000); chkEn("R3");
    wr(12'h058, 32'h0000_1018); chkEn("R2");
    wr(12'h058, 32'h0000_1019); chkEn("R3");
    wr(12'h05C, 32'h0000_1018); chkEn("R2");
    wr(12'h05C, 32'h0000_0018); chkEn("R3");

    for (int i = 0; i < ND; i++) wr(12'(12'h050 + 4 * i), 32'h0000_1018);
    chkEn("R2");
    wr(12'h04C, 32'h0);  chkEn("R6");
    wr(12'h064, 32'h0);  chkEn("R6");
    wr(12'h06C, 32'h0);  chkEn("R6");
    wr(12'h051, 32'h0);  chkEn("R6");
    wr(12'h056, 32'h0);  chkEn("R6");
    wr(12'h000, 32'h0);  chkEn("R6");
    rd(12'h04C, "R7");
    rd(12'h064, "R7");
    rd(12'h052, "R7");
    rd(12'hFFC, "R7");
    chkIdle("R7");
    for (int i = 0; i < ND; i++) rd(12'(12'h050 + 4 * i), "R5");
    wr(12'h05C, 32'hABCD_0000); chkEn("R8");
    rd(12'h05C, "R3");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule